// File: doc/BRIEF.md
# Primary Slot Page Selector

This block holds the primary slot mapping of an 8-bit home computer memory system. The processor sees 64 KB of memory as four 16 KB pages. Each page can be routed to one of four primary slots. One 8-bit register on the I/O bus holds four 2-bit slot numbers, one for each page. Software reads and writes this register at I/O port 0xA8.

For every memory request, the two top address bits choose a page. The block then raises exactly one of four slot-select strobes, the one matching the slot number stored for that page. Boot code that wants to map all pages to the slot it is running from does this with read-modify-write sequences. For that reason, readback always returns the last value written, and rewriting one page's field leaves the other pages where they were.

The block is synchronous to the processor clock. Reset is synchronous and active high. The readback data and the slot-select strobes are both registered, so each appears one clock after the request that produced it.

Top module: `pslot_map_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the mapping register is 0x00, `slot_sel` is 0000 and `rd_data` is 0x00.
- R2: At a clock edge where `iorq` and `io_wr` are high and the port is matched, the register takes `wr_data`. A read at that port (`iorq` and `io_rd` high) returns the stored byte on `rd_data` one cycle after the read cycle.
- R3: Only `addr[7:0]` is compared against the port number 0xA8, so address 0x12A8 selects the register. Address 0x00A9 does not: a write there is ignored, and a read there returns 0x00.
- R4: Page p (addresses p*0x4000 to p*0x4000+0x3FFF) takes its slot number from register bits [2p+1:2p]. Page 0 uses bits 1:0 and page 3 uses bits 7:6.
- R5: When `mreq` is high at a clock edge, `slot_sel` shows exactly one bit high in the next cycle. The bit set is bit s, where s is the field chosen by `addr[15:14]`.
- R6: When `mreq` is low at a clock edge, `slot_sel` is 0000 in the next cycle.
- R7: A memory request in the cycle right after a register write decodes with the newly written value.
- R8: A write strobe without `iorq` leaves the register unchanged.
- R9: `rd_data` is 0x00 in any cycle that does not follow a matched read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address; low byte is the I/O port, top two bits are the page |
| wr_data | input | 8 | Data from the processor for register writes |
| iorq | input | 1 | I/O request strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| mreq | input | 1 | Memory request strobe |
| rd_data | output | 8 | Registered readback of the mapping register |
| slot_sel | output | 4 | Registered one-hot primary slot select |

## Verification
The bench uses a mapping that sends each page to a different slot. This catches a design with swapped or shifted fields, which would raise the wrong strobe for some page. It writes through an address whose high byte is not zero, and through the neighbouring port 0xA9. A design that decodes all 16 address bits would miss the first write, and one that decodes too few bits would take the second. It issues a memory request in the cycle right after a write, so a mapping that lags by one cycle decodes the old slot. It changes one page field with a read-modify-write and then visits every page, so a write that disturbs neighbouring fields shows up as a wrong strobe.

// File: rtl/pslot_pkg.sv
package pslot_pkg;
  localparam int SLOT_W   = 2;
  localparam int PAGE_CNT = 4;
  localparam int MAP_W    = SLOT_W * PAGE_CNT;
  localparam int SLOT_CNT = 1 << SLOT_W;
  localparam int PAGE_BITS = $clog2(PAGE_CNT);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/pslot_io_port.sv
module pslot_io_port
  import pslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAP_W-1:0]  wr_data,
  input  logic              iorq,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [MAP_W-1:0]  map_q,
  output logic [MAP_W-1:0]  rd_data
);
  logic port_hit;
  logic wr_en;
  logic rd_en;

  // Only the low byte of the I/O address takes part in the match.
  assign port_hit = (addr[PORT_W-1:0] == PORT_ADDR);
  assign wr_en    = iorq && io_wr && port_hit;
  assign rd_en    = iorq && io_rd && port_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (wr_en) begin
      map_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= map_q;
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/pslot_page_decode.sv
module pslot_page_decode
  import pslot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic [MAP_W-1:0]  map_q,
  output logic [SLOT_CNT-1:0] slot_sel
);
  slot_t                 field_arr [PAGE_CNT];
  logic [PAGE_BITS-1:0]  page_idx;
  slot_t                 cur_slot;
  logic [SLOT_CNT-1:0]   onehot_d;

  // Unpack the register into one field per page.
  for (genvar p = 0; p < PAGE_CNT; p++) begin : g_field
    assign field_arr[p] = map_q[p*SLOT_W +: SLOT_W];
  end

  assign page_idx = addr[ADDR_W-1 -: PAGE_BITS];
  assign cur_slot = field_arr[page_idx];

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_sel
    assign onehot_d[s] = mreq && (cur_slot == SLOT_W'(s));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_sel <= '0;
    end else begin
      slot_sel <= onehot_d;
    end
  end
endmodule

// File: rtl/pslot_map_top.sv
module pslot_map_top
  import pslot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              iorq,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mreq,
  output logic [7:0]        rd_data,
  output logic [3:0]        slot_sel
);
  logic [MAP_W-1:0] map_q;

  pslot_io_port #(
    .ADDR_W   (ADDR_W),
    .PORT_W   (PORT_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_port (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_data(wr_data),
    .iorq   (iorq),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .map_q  (map_q),
    .rd_data(rd_data)
  );

  pslot_page_decode #(
    .ADDR_W(ADDR_W)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .mreq    (mreq),
    .map_q   (map_q),
    .slot_sel(slot_sel)
  );
endmodule

// File: rtl/pslot_map_chk.sv
module pslot_map_chk #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'hA8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              iorq,
  input logic              io_rd,
  input logic              io_wr,
  input logic              mreq,
  input logic [7:0]        rd_data,
  input logic [3:0]        slot_sel,
  input logic [7:0]        map_q
);
  logic hit_w;
  logic hit_r;
  assign hit_w = iorq && io_wr && (addr[PORT_W-1:0] == PORT_ADDR);
  assign hit_r = iorq && io_rd && (addr[PORT_W-1:0] == PORT_ADDR);

  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> (map_q == $past(wr_data)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !hit_w |=> $stable(map_q));

  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_r && !hit_w) |=> (rd_data == $past(map_q)));

  p_idle_read_r9: assert property (@(posedge clk) disable iff (rst)
    !hit_r |=> (rd_data == 8'h00));

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    mreq |=> ($countones(slot_sel) == 1));

  p_no_sel_r6: assert property (@(posedge clk) disable iff (rst)
    !mreq |=> (slot_sel == 4'b0000));
endmodule

bind pslot_map_top pslot_map_chk #(
  .ADDR_W   (ADDR_W),
  .PORT_W   (PORT_W),
  .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_data (wr_data),
  .iorq    (iorq),
  .io_rd   (io_rd),
  .io_wr   (io_wr),
  .mreq    (mreq),
  .rd_data (rd_data),
  .slot_sel(slot_sel),
  .map_q   (map_q)
);

// File: tb/pslot_map_top_bench.sv
module pslot_map_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic        iorq = 1'b0, io_rd = 1'b0, io_wr = 1'b0, mreq = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  slot_sel;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_map = 8'h00;

  typedef struct {
    logic [7:0] exp_rd;
    logic [3:0] exp_sel;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  pslot_map_top u_pslot_map_top (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
    .iorq(iorq), .io_rd(io_rd), .io_wr(io_wr), .mreq(mreq),
    .rd_data(rd_data), .slot_sel(slot_sel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Driver: applies one bus cycle and queues the expected registered result.
  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic i,
                     input logic r, input logic w, input logic m, input string tag);
    item_t it;
    logic [1:0] fld;
    @(negedge clk);
    addr = a; wr_data = d; iorq = i; io_rd = r; io_wr = w; mreq = m;
    fld = model_map[a[15:14]*2 +: 2];
    it.exp_sel = m ? (4'b0001 << fld) : 4'b0000;
    it.exp_rd  = (i && r && a[7:0] == 8'hA8) ? model_map : 8'h00;
    it.tag     = tag;
    if (i && w && a[7:0] == 8'hA8) model_map = d;
    @(posedge clk);
    #1;
    sb_q.push_back(it);
  endtask

  // Monitor: compares at the falling edge after the result registers.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check({it.tag, " rd_data"}, rd_data, it.exp_rd);
      check({it.tag, " slot_sel"}, {4'b0, slot_sel}, {4'b0, it.exp_sel});
    end
  end

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d, input string tag);
    bus(a, d, 1'b1, 1'b0, 1'b1, 1'b0, tag);
  endtask
  task automatic rd_port(input logic [15:0] a, input string tag);
    bus(a, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, tag);
  endtask
  task automatic mem(input logic [15:0] a, input string tag);
    bus(a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask
  task automatic idle(input string tag);
    bus(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset slot_sel", {4'b0, slot_sel}, 8'h00);
    rst = 1'b0;
    idle("R1 after reset");
    mem(16'hC123, "R1 all pages slot0");

    wr_port(16'h00A8, 8'hE4, "R2 write");
    rd_port(16'h00A8, "R2 readback");
    mem(16'h0100, "R4 page0");
    mem(16'h4100, "R4 page1");
    mem(16'h8100, "R5 page2");
    mem(16'hFFFF, "R5 page3");
    idle("R6 no mreq");
    bus(16'hC000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 addr no mreq");

    wr_port(16'h12A8, 8'h1B, "R3 high byte ignored write");
    rd_port(16'h77A8, "R3 high byte read");
    wr_port(16'h00A9, 8'hFF, "R3 wrong port write");
    rd_port(16'h00A8, "R3 wrong port ignored");
    rd_port(16'h00A9, "R9 wrong port read");
    bus(16'h00A8, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, "R8 no iorq");
    rd_port(16'h00A8, "R8 unchanged");

    // Read-modify-write of page 2 field only
    wr_port(16'h00A8, (8'h1B & 8'hCF) | 8'h30, "R4 rmw write");
    mem(16'h0000, "R4 rmw page0");
    mem(16'h4000, "R4 rmw page1");
    mem(16'h8000, "R4 rmw page2");
    mem(16'hC000, "R4 rmw page3");

    wr_port(16'h00A8, 8'h80, "R7 write");
    mem(16'hC000, "R7 next-cycle map");
    mem(16'h0000, "R7 page0");
    idle("R9 idle");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule